// File: doc/BRIEF.md
# Multi-Lane Serial Slave Engine

This block is the slave side of a synchronous serial link that moves bytes over one, two or four data lanes. An external master supplies the serial clock and an active-low select. The engine brings both into the system clock domain, finds the clock edges there, and shifts one lane group per sampling edge. It returns each finished byte as a parallel word with a one-cycle strobe.

On the transmit side, a single-entry holding register takes bytes through a valid/ready handshake. Its content moves into the transmit shifter when select becomes active and at every byte boundary. If the holding register is empty at that moment, the shifter is loaded with all ones.

The pad side is combinational from the select pin and the configuration. It gives a data value and an output enable for each lane, so the chip's tristate pads can be wired directly. The lane mode and the direction bit decide which lanes drive, which lanes receive and which lanes float. The configuration inputs are expected to be held steady while select is active.

Top module: `mlane_slave_engine`

## Requirements
- R1: With lane mode 2'b00 (single lane), lane 0 is the only lane that ever drives, and it drives exactly while select is low. Lane 1 is the serial input and never drives. Lanes 3 and 2 never drive.
- R2: With lane mode 2'b01 (dual: lanes 1:0) or 2'b10/2'b11 (quad: lanes 3:0), every active lane drives exactly when select is low and the direction bit is 0. No lane drives when select is high or when the direction bit is 1. Lanes 3 and 2 drive only in quad mode.
- R3: A byte is received MSB first in 8, 4 or 2 sampling edges for single, dual or quad mode. Within each group, the highest-numbered active lane carries the most significant bit, and in single mode the data comes from lane 1.
- R4: The byte being sent is placed on the driving lanes MSB first, using the same group order and lane weighting as R3.
- R5: Data is sampled on the rising serial clock edge when the polarity and phase settings are equal, and on the falling edge when they differ. The sent data advances after each sampling edge. Phase 0 presents the first group before the first edge.
- R6: Each completed byte appears on the receive data output together with a valid pulse one system cycle long. The pulse is raised only when the engine receives: in single mode, or in dual/quad mode with the direction bit at 1.
- R7: When select goes high, the group count returns to zero and any partial byte is dropped without a valid pulse. The next selected transfer starts a new byte.
- R8: While select is high, serial clock edges and lane data have no effect on the receive output or on the lane enables.
- R9: The transmit ready output is high exactly when the holding register is empty. A byte is accepted when valid and ready are both high. The holding register is emptied into the shifter when select becomes active and at each byte boundary, but only while the engine transmits (single mode, or dual/quad mode with direction 0).
- R10: When the holding register is empty at a load point, the byte sent next is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| sel_n_i | input | 1 | Active-low select from the master |
| lane_din_i | input | 4 | Values read back from the four lane pads |
| lane_dout_o | output | 4 | Values driven onto the lane pads |
| lane_oe_o | output | 4 | Output enable for each lane pad |
| lane_mode_i | input | 2 | 00 single, 01 dual, 10 or 11 quad |
| dir_i | input | 1 | Dual/quad direction: 0 engine drives, 1 engine receives |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Serial clock phase |
| rx_data_o | output | BYTE_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| tx_data_i | input | BYTE_W | Byte offered for transmission |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Holding register empty, byte will be accepted |

## Verification
The bench sweeps all three lane widths, both direction settings and all four polarity/phase pairs. Every frame has two bytes, and the master and slave byte values are derived arithmetically from the sweep indices. Data lost at the first or last group, swapped lane weights, or sampling on the wrong edge each show up as a wrong byte in a different corner of that sweep. The direction sweep separates the frames that must drive and pulse valid from those that must stay silent. Three further patterns cover the remaining cases: a byte aborted after three groups, clocks toggled while deselected, and a frame with nothing loaded. These check that partial data is dropped, that deselected activity is ignored, and that the idle byte is all ones.

// File: rtl/mls_pkg.sv
// Shared definitions for the multi-lane serial slave engine.
// Assumes a fixed pad count of four lanes.
package mls_pkg;
    localparam int unsigned NUM_LANES = 4;

    typedef enum logic [1:0] {
        LM_SINGLE = 2'd0,
        LM_DUAL   = 2'd1,
        LM_QUAD   = 2'd2,
        LM_QUAD_X = 2'd3
    } lane_mode_e;

    // Number of data lanes that carry bits in a given mode.
    function automatic int unsigned lanes_of(lane_mode_e m);
        case (m)
            LM_SINGLE: return 1;
            LM_DUAL:   return 2;
            default:   return 4;
        endcase
    endfunction
endpackage

// File: rtl/mls_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independently sampled; no bus coherence is implied.
module mls_sync #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Capture the asynchronous bits through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/mls_frontend.sv
// Brings serial clock, select and lane data into the system clock domain
// and turns serial clock transitions into a one-cycle sampling strobe.
// Assumes clk runs at least four times faster than the serial clock and
// that polarity/phase settings are static during a transfer.
module mls_frontend import mls_pkg::*; (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 sel_n_i,
    input  logic [NUM_LANES-1:0] lane_din_i,
    input  logic                 cpol_i,
    input  logic                 cpha_i,
    output logic                 sample_o,
    output logic                 active_o,
    output logic                 sel_fall_o,
    output logic [NUM_LANES-1:0] lane_s_o
);
    localparam int unsigned SYNC_W = NUM_LANES + 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, {NUM_LANES{1'b0}}};

    logic [SYNC_W-1:0] sync_q;
    logic              sclk_s;
    logic              sel_n_s;
    logic              sclk_d;
    logic              sel_n_d;
    logic              rise;
    logic              fall;

    mls_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_n_i, sclk_i, lane_din_i}),
        .q_o   (sync_q)
    );

    assign sel_n_s  = sync_q[SYNC_W-1];
    assign sclk_s   = sync_q[SYNC_W-2];
    assign lane_s_o = sync_q[NUM_LANES-1:0];

    // Keep one more stage of clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            sel_n_d <= 1'b1;
        end else begin
            sclk_d  <= sclk_s;
            sel_n_d <= sel_n_s;
        end
    end

    // Choose the sampling edge from polarity and phase.
    always_comb begin
        rise     = sclk_s & ~sclk_d;
        fall     = ~sclk_s & sclk_d;
        active_o = ~sel_n_s;
        sample_o = active_o & ((cpol_i == cpha_i) ? rise : fall);
        sel_fall_o = ~sel_n_s & sel_n_d;
    end
endmodule

// File: rtl/mls_datapath.sv
// Group counter, receive shifter, transmit shifter and transmit holding
// register. One lane group moves per sampling strobe.
// Assumes BYTE_W is a multiple of four and at least eight.
module mls_datapath import mls_pkg::*; #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lane_mode_e           mode_i,
    input  logic                 dir_i,
    input  logic                 sample_i,
    input  logic                 active_i,
    input  logic                 sel_fall_i,
    input  logic [NUM_LANES-1:0] lane_s_i,
    input  logic [BYTE_W-1:0]    tx_data_i,
    input  logic                 tx_valid_i,
    output logic                 tx_ready_o,
    output logic [BYTE_W-1:0]    rx_data_o,
    output logic                 rx_valid_o,
    output logic [NUM_LANES-1:0] tx_top_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  grp_cnt;
    logic [CNT_W-1:0]  last_grp;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] rx_next;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] tx_next;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] fresh;
    logic              hold_full;
    logic              transmit;
    logic              receive;
    logic              byte_done;
    logic              load_pt;

    // Per-mode group limit and shifted register values.
    always_comb begin
        case (mode_i)
            LM_SINGLE: begin
                last_grp = CNT_W'(BYTE_W - 1);
                rx_next  = {rx_sr[BYTE_W-2:0], lane_s_i[1]};
                tx_next  = {tx_sr[BYTE_W-2:0], 1'b0};
            end
            LM_DUAL: begin
                last_grp = CNT_W'(BYTE_W / 2 - 1);
                rx_next  = {rx_sr[BYTE_W-3:0], lane_s_i[1:0]};
                tx_next  = {tx_sr[BYTE_W-3:0], 2'b00};
            end
            default: begin
                last_grp = CNT_W'(BYTE_W / 4 - 1);
                rx_next  = {rx_sr[BYTE_W-5:0], lane_s_i[3:0]};
                tx_next  = {tx_sr[BYTE_W-5:0], 4'b0000};
            end
        endcase
    end

    // Role decode and load-point detection.
    always_comb begin
        transmit  = (mode_i == LM_SINGLE) || !dir_i;
        receive   = (mode_i == LM_SINGLE) || dir_i;
        byte_done = sample_i && (grp_cnt == last_grp);
        load_pt   = sel_fall_i || byte_done;
        fresh     = (transmit && hold_full) ? hold_q : '1;
    end

    // Receive shifting, group counting and byte delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_cnt    <= '0;
            rx_sr      <= '0;
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (!active_i) begin
                grp_cnt <= '0;
                rx_sr   <= '0;
            end else if (sample_i) begin
                rx_sr <= rx_next;
                if (byte_done) begin
                    grp_cnt    <= '0;
                    rx_data_o  <= rx_next;
                    rx_valid_o <= receive;
                end else begin
                    grp_cnt <= grp_cnt + 1'b1;
                end
            end
        end
    end

    // Transmit shifter: reload at load points, advance after each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '1;
        end else if (load_pt) begin
            tx_sr <= fresh;
        end else if (sample_i) begin
            tx_sr <= tx_next;
        end
    end

    // Single-entry holding register with valid/ready acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (tx_valid_i && !hold_full) begin
            hold_q    <= tx_data_i;
            hold_full <= 1'b1;
        end else if (load_pt && transmit) begin
            hold_full <= 1'b0;
        end
    end

    assign tx_ready_o = !hold_full;
    assign tx_top_o   = tx_sr[BYTE_W-1 -: NUM_LANES];
endmodule

// File: rtl/mls_pads.sv
// Per-lane output enable and data for the tristate pads.
// Purely combinational from the raw select pin, so lanes release at once.
module mls_pads import mls_pkg::*; (
    input  logic                 sel_n_i,
    input  lane_mode_e           mode_i,
    input  logic                 dir_i,
    input  logic [NUM_LANES-1:0] tx_top_i,
    output logic [NUM_LANES-1:0] oe_o,
    output logic [NUM_LANES-1:0] dout_o
);
    logic [NUM_LANES-1:0] grp;
    logic [NUM_LANES-1:0] mask;

    // Align the outgoing group to the lanes of the current mode.
    always_comb begin
        case (mode_i)
            LM_SINGLE: grp = {3'b000, tx_top_i[3]};
            LM_DUAL:   grp = {2'b00, tx_top_i[3:2]};
            default:   grp = tx_top_i;
        endcase
    end

    // Per-lane drive decision from mode, direction and select.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        always_comb begin
            if (sel_n_i) begin
                mask[i] = 1'b0;
            end else if (mode_i == LM_SINGLE) begin
                mask[i] = (i == 0);
            end else begin
                mask[i] = !dir_i && (i < int'(lanes_of(mode_i)));
            end
        end
    end

    assign oe_o   = mask;
    assign dout_o = grp & mask;
endmodule

// File: rtl/mlane_slave_engine.sv
// Top level of the multi-lane serial slave engine: synchronizing front end,
// shifting datapath and pad control.
// Assumes clk is at least four times the serial clock and the configuration
// inputs stay constant while select is low.
module mlane_slave_engine import mls_pkg::*; #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sel_n_i,
    input  logic [3:0]        lane_din_i,
    output logic [3:0]        lane_dout_o,
    output logic [3:0]        lane_oe_o,
    input  logic [1:0]        lane_mode_i,
    input  logic              dir_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o
);
    lane_mode_e           mode;
    logic                 sample;
    logic                 active;
    logic                 sel_fall;
    logic [NUM_LANES-1:0] lane_s;
    logic [NUM_LANES-1:0] tx_top;

    assign mode = lane_mode_e'(lane_mode_i);

    mls_frontend i_frontend (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk_i),
        .sel_n_i    (sel_n_i),
        .lane_din_i (lane_din_i),
        .cpol_i     (cpol_i),
        .cpha_i     (cpha_i),
        .sample_o   (sample),
        .active_o   (active),
        .sel_fall_o (sel_fall),
        .lane_s_o   (lane_s)
    );

    mls_datapath #(.BYTE_W(BYTE_W)) i_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .dir_i      (dir_i),
        .sample_i   (sample),
        .active_i   (active),
        .sel_fall_i (sel_fall),
        .lane_s_i   (lane_s),
        .tx_data_i  (tx_data_i),
        .tx_valid_i (tx_valid_i),
        .tx_ready_o (tx_ready_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .tx_top_o   (tx_top)
    );

    mls_pads i_pads (
        .sel_n_i  (sel_n_i),
        .mode_i   (mode),
        .dir_i    (dir_i),
        .tx_top_i (tx_top),
        .oe_o     (lane_oe_o),
        .dout_o   (lane_dout_o)
    );
endmodule

// File: rtl/mls_checker.sv
// Port-level properties of the multi-lane serial slave engine.
module mls_checker #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n_i,
    input logic [1:0]        lane_mode_i,
    input logic              dir_i,
    input logic [3:0]        lane_oe_o,
    input logic              rx_valid_o,
    input logic [BYTE_W-1:0] rx_data_o,
    input logic              tx_valid_i,
    input logic              tx_ready_o
);
    a_r2_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_i |-> (lane_oe_o == 4'b0000));

    a_r1_lane1_input_only: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode_i == 2'b00) |-> !lane_oe_o[1]);

    a_r2_upper_lanes_quad: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe_o[3:2] != 2'b00) |-> lane_mode_i[1]);

    a_r2_receive_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_mode_i != 2'b00) && dir_i) |-> (lane_oe_o == 4'b0000));

    a_r6_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> $stable(rx_data_o));

    a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

    a_r8_no_strobe_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_i && $past(sel_n_i) && $past(sel_n_i, 2) && $past(sel_n_i, 3))
        |-> !rx_valid_o);
endmodule

bind mlane_slave_engine mls_checker #(.BYTE_W(BYTE_W)) i_mls_checker (.*);

// File: tb/test_mlane_slave_engine.sv
// Sweep bench for the multi-lane serial slave engine.
module test_mlane_slave_engine;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sel_n = 1'b1;
    logic [3:0] lane_in = 4'h0;
    logic [3:0] lane_out;
    logic [3:0] lane_oe;
    logic [1:0] lmode = 2'b00;
    logic       dir = 1'b0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;

    int         checks = 0;
    int         errors = 0;
    int         vcount = 0;
    int         doubles = 0;
    logic       last_v = 1'b0;
    logic [7:0] rx_log [0:15];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mlane_slave_engine i_mlane_slave_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .sel_n_i     (sel_n),
        .lane_din_i  (lane_in),
        .lane_dout_o (lane_out),
        .lane_oe_o   (lane_oe),
        .lane_mode_i (lmode),
        .dir_i       (dir),
        .cpol_i      (cpol),
        .cpha_i      (cpha),
        .rx_data_o   (rx_data),
        .rx_valid_o  (rx_valid),
        .tx_data_i   (tx_data),
        .tx_valid_i  (tx_valid),
        .tx_ready_o  (tx_ready)
    );

    // Record every received byte away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_log[vcount % 16] = rx_data;
            vcount = vcount + 1;
            if (last_v) doubles = doubles + 1;
        end
        last_v = rx_valid;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_oe(input int mode, input bit d, input bit seln);
        if (seln) return 4'b0000;
        if (mode == 0) return 4'b0001;
        if (d) return 4'b0000;
        return (mode == 1) ? 4'b0011 : 4'b1111;
    endfunction

    function automatic logic [3:0] place(input int mode, input logic [3:0] g);
        if (mode == 0) return {2'b00, g[0], 1'b0};
        if (mode == 1) return {2'b00, g[1:0]};
        return g;
    endfunction

    function automatic logic [3:0] take(input int mode, input logic [3:0] o);
        if (mode == 0) return {3'b000, o[0]};
        if (mode == 1) return {2'b00, o[1:0]};
        return o;
    endfunction

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // One selected transfer of nb bytes acting as the master.
    task automatic frame(input int mode, input bit d, input bit cp, input bit ch,
                         input int nb, input logic [7:0] m0, input logic [7:0] m1,
                         input logic [7:0] s0, input logic [7:0] s1, input bit pu);
        int         w;
        int         ng;
        int         v0;
        bit         xmit;
        bit         recv;
        logic [7:0] mb;
        logic [7:0] sb;
        logic [7:0] got;
        logic [3:0] grp;
        string      oe_req;
        w      = (mode == 0) ? 1 : ((mode == 1) ? 2 : 4);
        ng     = 8 / w;
        xmit   = (mode == 0) || !d;
        recv   = (mode == 0) || d;
        oe_req = (mode == 0) ? "R1" : "R2";
        lmode  = 2'(mode);
        dir    = d;
        cpol   = cp;
        cpha   = ch;
        sclk   = cp;
        @(negedge clk);
        if (pu) begin
            push(s0);
            chk(!tx_ready, "R9", "ready low with byte held", int'(tx_ready), 0);
        end
        v0    = vcount;
        sel_n = 1'b0;
        repeat (8) @(negedge clk);
        if (pu) begin
            chk(tx_ready, "R9", "ready back after select load", int'(tx_ready), 1);
            if (nb > 1) push(s1);
        end
        for (int b = 0; b < nb; b++) begin
            mb  = (b == 0) ? m0 : m1;
            sb  = !pu ? 8'hFF : ((b == 0) ? s0 : s1);
            got = 8'h00;
            for (int g = 0; g < ng; g++) begin
                grp = 4'((int'(mb) >> (8 - (g + 1) * w)) & ((1 << w) - 1));
                if (!ch) begin
                    lane_in = place(mode, grp);
                    wait_half();
                end else begin
                    sclk = ~sclk;
                    lane_in = place(mode, grp);
                    wait_half();
                end
                got = 8'((int'(got) << w) | int'(take(mode, lane_out)));
                chk(lane_oe == exp_oe(mode, d, 1'b0), oe_req, "lane enables while selected",
                    int'(lane_oe), int'(exp_oe(mode, d, 1'b0)));
                sclk = ~sclk;
                wait_half();
                if (!ch) sclk = ~sclk;
            end
            if (xmit) chk(got == sb, "R4", "byte seen on driving lanes", int'(got), int'(sb));
        end
        wait_half();
        sel_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(lane_oe == 4'b0000, oe_req, "lanes released after deselect", int'(lane_oe), 0);
        chk(vcount - v0 == (recv ? nb : 0), "R6", "valid pulse count", vcount - v0,
            recv ? nb : 0);
        if (recv) begin
            for (int b = 0; b < nb; b++) begin
                mb = (b == 0) ? m0 : m1;
                chk(rx_log[(v0 + b) % 16] == mb, "R3 R5", "received byte",
                    int'(rx_log[(v0 + b) % 16]), int'(mb));
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        logic [7:0] m0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_valid, "R6", "no strobe after reset", int'(rx_valid), 0);
        chk(rx_data == 8'h00, "R6", "receive data cleared", int'(rx_data), 0);
        chk(tx_ready, "R9", "holding register empty after reset", int'(tx_ready), 1);
        chk(lane_oe == 4'b0000, "R1", "lanes idle after reset", int'(lane_oe), 0);

        // Sweep every lane mode, direction and polarity/phase pair.
        for (int mode = 0; mode < 3; mode++) begin
            for (int d = 0; d < 2; d++) begin
                for (int k = 0; k < 4; k++) begin
                    m0 = 8'((mode * 61 + d * 29 + k * 17 + 3) & 255);
                    frame(mode, d[0], k[1], k[0], 2, m0, ~m0 ^ 8'(k),
                          8'((int'(m0) * 3 + 1) & 255), m0 ^ 8'hA5,
                          (mode == 0) || (d == 0));
                end
            end
        end

        // R7: abort a byte after three groups, then a fresh byte.
        lmode = 2'b00; dir = 1'b0; cpol = 1'b0; cpha = 1'b0; sclk = 1'b0;
        v0 = vcount;
        sel_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int g = 0; g < 3; g++) begin
            lane_in = 4'b0010;
            wait_half();
            sclk = 1'b1;
            wait_half();
            sclk = 1'b0;
        end
        wait_half();
        sel_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(vcount == v0, "R7", "no strobe for aborted byte", vcount - v0, 0);
        // R10: nothing loaded, so the engine sends all ones.
        frame(0, 1'b0, 1'b0, 1'b0, 1, 8'h5A, 8'h00, 8'h00, 8'h00, 1'b0);
        chk(rx_log[(vcount - 1) % 16] == 8'h5A, "R7", "byte after abort starts clean",
            int'(rx_log[(vcount - 1) % 16]), 'h5A);

        // R8: clock and data activity while deselected is ignored.
        v0 = vcount;
        for (int t = 0; t < 10; t++) begin
            lane_in = 4'(t * 7);
            sclk = ~sclk;
            wait_half();
        end
        chk(vcount == v0, "R8", "no strobe while deselected", vcount - v0, 0);
        chk(lane_oe == 4'b0000, "R8", "lanes stay released while deselected", int'(lane_oe), 0);
        frame(2, 1'b1, 1'b1, 1'b0, 1, 8'hC3, 8'h00, 8'h00, 8'h00, 1'b0);
        chk(rx_log[(vcount - 1) % 16] == 8'hC3, "R8", "first byte after ignored clocks",
            int'(rx_log[(vcount - 1) % 16]), 'hC3);
        chk(doubles == 0, "R6", "strobes one cycle wide", doubles, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule